// File: doc/BRIEF.md
# Per-Block Write/Read Protection Register Bank

This block holds one small protection register for each block of a flash array. A host reaches the registers through a plain register port: pick a block with an address, write new lock bits, and read the current bits back. Two query ports answer questions for the rest of the memory. The program/erase side asks whether a block may be modified. The read side asks whether array data from a block may be returned.

Each register has three controls. The write lock stops programs and erases to the block. The read lock hides the block's data behind zeros. The lock-down control freezes the register: once it is set, no register write changes anything until the next reset. When a program or erase request targets a write-locked block, the request is refused and a one-cycle protection-violation pulse follows. Host bus decoding, general-purpose input registers and the array itself are handled elsewhere.

Top module: `lock_reg_bank`

## Requirements
- R1: On reset, every register reads 0x01: write lock is set, and read lock and lock-down are clear. As a result `pe_allow` is low and `rd_allow` is high for every block.
- R2: A write to a register whose lock-down bit is 0 loads `reg_wdata` into it with this encoding: bit 0 is write lock, bit 1 is lock-down, bit 2 is read lock. `reg_rdata` returns the same three bits in positions 2:0, and bits 7:3 always read 0.
- R3: Once a register's lock-down bit is 1, writes to it are ignored. This includes writes that try to clear lock-down. Only reset clears it.
- R4: A register write changes only the register chosen by `reg_addr`.
- R5: `pe_allow` is the inverse of the write lock of block `pe_blk`, in the same cycle. `pe_grant` is high exactly when `pe_req` is high and `pe_allow` is high.
- R6: `prot_viol` is high in the cycle after a cycle with `pe_req` high on a write-locked block. It is low in every other cycle.
- R7: `rd_allow` is the inverse of the read lock of block `rd_blk`. `rd_data` equals `arr_rdata` when `rd_allow` is high and 0x00 otherwise.
- R8: Activity on the read port (`rd_blk`, `arr_rdata`) never raises `prot_viol`.
- R9: A register write takes effect at the next rising clock edge. Queries in the same cycle as the write still see the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | BLK_AW | Block selected for a register read or write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 3 | New lock bits (bit 0 write lock, bit 1 lock-down, bit 2 read lock) |
| reg_rdata | output | DATA_W | Lock bits of the selected block, zero-extended |
| pe_req | input | 1 | Program or erase request |
| pe_blk | input | BLK_AW | Block targeted by the program/erase request |
| pe_allow | output | 1 | Target block is not write-locked |
| pe_grant | output | 1 | Request may proceed |
| prot_viol | output | 1 | One-cycle pulse after a refused request |
| rd_blk | input | BLK_AW | Block being read from the array |
| arr_rdata | input | DATA_W | Raw array data |
| rd_allow | output | 1 | Target block is not read-locked |
| rd_data | output | DATA_W | Array data, or 0x00 when read-locked |

## Verification
The hardest state to reach is a register frozen by lock-down that then receives writes trying to undo it. This includes a write that clears lock-down itself, arriving while the same block is being queried. The stimulus first writes lock-down into one block. It then aims later writes of all-zero and of other patterns at that block, then applies a mid-run reset to show the freeze lifts. A long random phase follows, with writes, requests and occasional resets. Because writes are frequent in that phase, frozen registers keep receiving writes alongside program requests in the same cycle.

// File: rtl/lockbank_pkg.sv
// Package: shared types for the protection register bank.
// Assumes: the lock field is three bits wide and its bit order is fixed
// (bit 0 write lock, bit 1 lock-down, bit 2 read lock).
package lockbank_pkg;

    localparam int LOCK_W = 3;

    typedef struct packed {
        logic rd_lock;    // bit 2
        logic lock_down;  // bit 1
        logic wr_lock;    // bit 0
    } lock_bits_t;

    localparam lock_bits_t LOCK_RESET = '{rd_lock: 1'b0, lock_down: 1'b0, wr_lock: 1'b1};
    localparam lock_bits_t LOCK_ALL   = '{rd_lock: 1'b1, lock_down: 1'b1, wr_lock: 1'b1};

endpackage

// File: rtl/lock_cell.sv
// Module: one protection register.
// Loads new lock bits on a decoded write strobe unless lock-down is already
// set. Once lock-down is set, the register holds until synchronous reset.
// Assumes: wr_en has already been qualified by the address decode.
module lock_cell
    import lockbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  lock_bits_t wr_bits,
    output lock_bits_t bits_q
);

    // Register update: reset to write-protected, otherwise load when not frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= LOCK_RESET;
        end else if (wr_en && !bits_q.lock_down) begin
            bits_q <= wr_bits;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (bits_q == LOCK_RESET));

    // R3
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q.lock_down |=> bits_q.lock_down);

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_q.lock_down && wr_en) |=> $stable(bits_q));

endmodule

// File: rtl/lock_query.sv
// Module: combinational selection of lock bits for the three consumers.
// It serves the register read port, the program/erase check and the read check.
// An index outside the bank is treated as fully locked.
// Assumes: NUM_BLOCKS >= 2.
module lock_query
    import lockbank_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_AW     = $clog2(NUM_BLOCKS)
) (
    input  lock_bits_t [NUM_BLOCKS-1:0] bank,
    input  logic [BLK_AW-1:0]           reg_addr,
    input  logic [BLK_AW-1:0]           pe_blk,
    input  logic [BLK_AW-1:0]           rd_blk,
    output lock_bits_t                  reg_bits,
    output logic                        pe_locked,
    output logic                        rd_locked
);

    lock_bits_t pe_bits;
    lock_bits_t rd_bits;

    // Register read selection
    always_comb begin
        reg_bits = (int'(reg_addr) < NUM_BLOCKS) ? bank[reg_addr] : LOCK_ALL;
    end

    // Program/erase target selection
    always_comb begin
        pe_bits   = (int'(pe_blk) < NUM_BLOCKS) ? bank[pe_blk] : LOCK_ALL;
        pe_locked = pe_bits.wr_lock;
    end

    // Read target selection
    always_comb begin
        rd_bits   = (int'(rd_blk) < NUM_BLOCKS) ? bank[rd_blk] : LOCK_ALL;
        rd_locked = rd_bits.rd_lock;
    end

endmodule

// File: rtl/lock_viol.sv
// Module: protection-violation pulse generator.
// Registers a refused program/erase request into a one-cycle pulse.
// Assumes: pe_locked is valid whenever pe_req is high.
module lock_viol (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_req,
    input  logic pe_locked,
    output logic prot_viol
);

    // Pulse register: set for one cycle after each refused request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_viol <= 1'b0;
        end else begin
            prot_viol <= pe_req && pe_locked;
        end
    end

endmodule

// File: rtl/lock_reg_bank.sv
// Module: top of the per-block protection register bank.
// It decodes register writes to one cell per block, selects lock bits for the
// query ports, gates the program/erase request, masks read data and raises the
// violation pulse.
// Assumes: DATA_W >= 3 and NUM_BLOCKS >= 2.
module lock_reg_bank
    import lockbank_pkg::*;
#(
    parameter  int NUM_BLOCKS = 8,
    parameter  int DATA_W     = 8,
    localparam int BLK_AW     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_AW-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [LOCK_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pe_req,
    input  logic [BLK_AW-1:0] pe_blk,
    output logic              pe_allow,
    output logic              pe_grant,
    output logic              prot_viol,
    input  logic [BLK_AW-1:0] rd_blk,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              rd_allow,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - LOCK_W;

    lock_bits_t [NUM_BLOCKS-1:0] bank;
    lock_bits_t                  reg_bits;
    lock_bits_t                  wr_bits;
    logic                        pe_locked;
    logic                        rd_locked;

    assign wr_bits = lock_bits_t'(reg_wdata);

    // One register per block, each with its own decoded write strobe
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cell
        logic cell_wr;
        assign cell_wr = reg_wr_en && (reg_addr == BLK_AW'(g));
        lock_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cell_wr),
            .wr_bits(wr_bits),
            .bits_q (bank[g])
        );
    end

    lock_query #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_AW    (BLK_AW)
    ) i_query (
        .bank     (bank),
        .reg_addr (reg_addr),
        .pe_blk   (pe_blk),
        .rd_blk   (rd_blk),
        .reg_bits (reg_bits),
        .pe_locked(pe_locked),
        .rd_locked(rd_locked)
    );

    lock_viol i_viol (
        .clk      (clk),
        .rst_n    (rst_n),
        .pe_req   (pe_req),
        .pe_locked(pe_locked),
        .prot_viol(prot_viol)
    );

    // Output formatting: zero-extend lock bits, gate request, mask read data
    always_comb begin
        reg_rdata = {{PAD_W{1'b0}}, reg_bits};
        pe_allow  = !pe_locked;
        pe_grant  = pe_req && !pe_locked;
        rd_allow  = !rd_locked;
        rd_data   = rd_locked ? '0 : arr_rdata;
    end

    // R6
    viol_after_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && !pe_allow) |=> prot_viol);

    // R6
    viol_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |-> $past(pe_req && !pe_allow));

    // R5
    grant_excludes_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_grant |=> !prot_viol);

    // R7
    read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_allow |-> (rd_data == '0));

endmodule

// File: tb/test_lock_reg_bank.sv
module test_lock_reg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          pe_req = 1'b0;
    logic [AW-1:0] pe_blk = '0;
    logic          pe_allow;
    logic          pe_grant;
    logic          prot_viol;
    logic [AW-1:0] rd_blk = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic          rd_allow;
    logic [DW-1:0] rd_data;

    lock_reg_bank #(.NUM_BLOCKS(NB), .DATA_W(DW)) i_lock_reg_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pe_req(pe_req), .pe_blk(pe_blk), .pe_allow(pe_allow),
        .pe_grant(pe_grant), .prot_viol(prot_viol),
        .rd_blk(rd_blk), .arr_rdata(arr_rdata), .rd_allow(rd_allow),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model: per block integers for the three controls
    int m_wl[NB];
    int m_ld[NB];
    int m_rl[NB];
    int exp_viol = 0;
    bit started = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_reg(int b);
        return m_wl[b] + 2 * m_ld[b] + 4 * m_rl[b];
    endfunction

    // Compare every output against the model, then advance one clock
    task automatic tick();
        #1;
        if (started) begin
            check("R2", "reg_rdata", int'(reg_rdata), model_reg(int'(reg_addr)));
            check("R5", "pe_allow", int'(pe_allow), 1 - m_wl[pe_blk]);
            check("R5", "pe_grant", int'(pe_grant), int'(pe_req) * (1 - m_wl[pe_blk]));
            check("R6", "prot_viol", int'(prot_viol), exp_viol);
            check("R7", "rd_allow", int'(rd_allow), 1 - m_rl[rd_blk]);
            check("R7", "rd_data", int'(rd_data), m_rl[rd_blk] != 0 ? 0 : int'(arr_rdata));
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_wl[b] = 1; m_ld[b] = 0; m_rl[b] = 0;
            end
            exp_viol = 0;
            started = 1;
        end else begin
            exp_viol = (pe_req && m_wl[pe_blk] != 0) ? 1 : 0;
            if (reg_wr_en && m_ld[reg_addr] == 0) begin
                m_wl[reg_addr] = int'(reg_wdata[0]);
                m_ld[reg_addr] = int'(reg_wdata[1]);
                m_rl[reg_addr] = int'(reg_wdata[2]);
            end
        end
        @(negedge clk);
    endtask

    task automatic write_reg(int b, int v);
        reg_addr = AW'(b); reg_wdata = 3'(v); reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic read_expect(string req, int b, int exp);
        reg_addr = AW'(b);
        #1;
        check(req, "register readback", int'(reg_rdata), exp);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;

        // R1: reset state for every block
        for (int b = 0; b < NB; b++) begin
            pe_blk = AW'(b); rd_blk = AW'(b);
            #1;
            check("R1", "pe_allow after reset", int'(pe_allow), 0);
            check("R1", "rd_allow after reset", int'(rd_allow), 1);
            read_expect("R1", b, 1);
        end

        // R2: upper bits of readback are zero, bit order honoured
        write_reg(2, 0);
        read_expect("R2", 2, 0);
        write_reg(5, 4);
        read_expect("R2", 5, 4);
        // R4: neighbours untouched
        read_expect("R4", 4, 1);
        read_expect("R4", 6, 1);

        // R9: write and query in the same cycle sees the old value
        pe_blk = 3'd2; reg_addr = 3'd2; reg_wdata = 3'd1; reg_wr_en = 1'b1;
        #1;
        check("R9", "pe_allow before write edge", int'(pe_allow), 1);
        tick();
        reg_wr_en = 1'b0;
        #1;
        check("R9", "pe_allow after write edge", int'(pe_allow), 0);

        // R6: refused request on a locked block pulses once
        pe_blk = 3'd2; pe_req = 1'b1;
        tick();
        pe_req = 1'b0;
        #1;
        check("R6", "prot_viol after locked request", int'(prot_viol), 1);
        tick();
        #1;
        check("R6", "prot_viol drops after one cycle", int'(prot_viol), 0);
        pe_blk = 3'd5; pe_req = 1'b1;
        #1;
        check("R5", "pe_grant on unlocked block", int'(pe_grant), 1);
        tick();
        pe_req = 1'b0;
        #1;
        check("R6", "no prot_viol on unlocked block", int'(prot_viol), 0);

        // R7 and R8: read lock masks data and raises no violation
        arr_rdata = 8'hA5; rd_blk = 3'd5;
        #1;
        check("R7", "rd_data masked", int'(rd_data), 0);
        tick();
        #1;
        check("R8", "no prot_viol from read", int'(prot_viol), 0);
        rd_blk = 3'd2;
        #1;
        check("R7", "rd_data passes", int'(rd_data), 'hA5);
        tick();

        // R3: lock-down freezes the register, only reset releases it
        write_reg(3, 2);
        read_expect("R3", 3, 2);
        write_reg(3, 5);
        read_expect("R3", 3, 2);
        write_reg(3, 0);
        read_expect("R3", 3, 2);
        write_reg(4, 0);
        read_expect("R4", 4, 0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        read_expect("R3", 3, 1);
        write_reg(3, 4);
        read_expect("R3", 3, 4);

        // Random phase, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            rst_n     = ($urandom_range(0, 199) != 0);
            reg_addr  = AW'($urandom);
            reg_wr_en = ($urandom_range(0, 2) == 0);
            reg_wdata = 3'($urandom);
            pe_req    = $urandom_range(0, 1) != 0;
            pe_blk    = AW'($urandom);
            rd_blk    = AW'($urandom);
            arr_rdata = DW'($urandom);
            tick();
        end
        rst_n = 1'b1; reg_wr_en = 1'b0; pe_req = 1'b0;
        tick();
        finish_run();
    end

endmodule